// File: doc/BRIEF.md
# Address translation configuration controller

This block derives a 7-bit bus address translation value from two digitized configuration ratios and applies it to address bytes. Each ratio is an unsigned 8-bit code giving a pin voltage as a fraction of supply. The lower ratio supplies a 4-bit field and the upper ratio supplies a 3-bit field. Both use the same sixteen equal bins.

The translation value is latched once after the block is enabled, on the first sample-valid strobe. It is held until shutdown, which is enable low or the undervoltage flag high. Shutdown clears the value, drops READY and opens the bus switch. The value can be changed during operation by taking enable high, then low, then high again, which re-samples both ratios.

While READY is high, the incoming address byte leaves XORed with the translation byte. Otherwise the address passes through unchanged. The read/write bit (bit 0) is never altered.

Top module: `xlat_cfg_ctrl`

## Requirements
- R1: The low field (translation byte bits 4:1) equals bits 7:4 of `ratio_lo_i`. Bin edges therefore sit at multiples of 16 codes, so 15 maps to 0, 16 to 1, 31 to 1 and 32 to 2.
- R2: Low ratios of 8 or below (at most 1/32 of supply) give a low field of 0. Low ratios of 248 or above (at least 31/32) give 15.
- R3: The high field (translation byte bits 7:5) equals bits 6:4 of `ratio_hi_i` when that ratio is below 128. For any ratio of 128 or more it saturates at 7.
- R4: Bit 0 of the translation byte is always 0, and bit 0 of `addr_o` always equals bit 0 of `addr_i`.
- R5: After reset, `xlat_byte_o` is 0 and `ready_o` and `sw_en_o` are low.
- R6: After enable rises with undervoltage clear, the ratios are captured only on a cycle with `smp_vld_i` high. Until then `xlat_byte_o` stays 0 and `ready_o` stays low.
- R7: The captured byte appears on `xlat_byte_o` on the edge after the strobe. `ready_o` and `sw_en_o` rise together one cycle later.
- R8: One edge after `en_i` goes low or `uv_i` goes high, `xlat_byte_o` is 0 and `ready_o` and `sw_en_o` are low.
- R9: While ready, further strobes with new ratios leave the byte unchanged. A high-low-high sequence on `en_i` loads the new ratios.
- R10: `addr_o` equals `addr_i ^ xlat_byte_o` while `ready_o` is high, and equals `addr_i` otherwise.
- R11: Equal ratios on both inputs (a shared divider) decode normally. For example, 0x50 on both gives 0xAA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Enable; low forces shutdown |
| uv_i | input | 1 | Undervoltage flag; high forces shutdown |
| smp_vld_i | input | 1 | Ratio samples are valid this cycle |
| ratio_lo_i | input | 8 | Lower configuration ratio code |
| ratio_hi_i | input | 8 | Upper configuration ratio code |
| addr_i | input | 8 | Framed incoming address byte |
| xlat_byte_o | output | 8 | Stored translation byte, LSB zero |
| ready_o | output | 1 | Translation active |
| sw_en_o | output | 1 | Bus switch enable |
| addr_o | output | 8 | Translated address byte |

## Verification
The embedded properties check several rules on every cycle: the clearing on shutdown, the byte held at zero while waiting for a strobe, READY rising only after the load state, the byte stable while ready, and upper-field saturation. Only the bench's scenarios can show the exact decoded values at bin edges and extremes, the re-toggle reload, the shared-ratio case and the XOR path on `addr_o`.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int unsigned BIN_W = 4;  // 16 bins of 1/16 supply

  typedef enum logic [1:0] {
    ST_OFF,
    ST_WAIT,
    ST_LOAD,
    ST_RUN
  } xlat_st_e;
endpackage

// File: rtl/xlat_quant.sv
module xlat_quant #(
  parameter int unsigned RATIO_W = 8,
  parameter int unsigned FIELD_W = 4
) (
  input  logic [RATIO_W-1:0] ratio_i,
  output logic [FIELD_W-1:0] code_o
);
  import xlat_pkg::*;

  localparam int unsigned MAX_CODE = (1 << FIELD_W) - 1;

  logic [BIN_W-1:0] bin;
  assign bin = ratio_i[RATIO_W-1 -: BIN_W];

  generate
    if (FIELD_W >= BIN_W) begin : g_full
      assign code_o = FIELD_W'(bin);
    end else begin : g_sat
      // ratios past the last usable bin clamp to the top code
      always_comb begin
        if (bin > BIN_W'(MAX_CODE)) code_o = FIELD_W'(MAX_CODE);
        else                        code_o = bin[FIELD_W-1:0];
      end
    end
  endgenerate

  // R3
  always_comb begin
    if (FIELD_W < BIN_W && ratio_i[RATIO_W-1])
      sat_top_chk: assert (code_o == FIELD_W'(MAX_CODE));
  end
endmodule

// File: rtl/xlat_seq.sv
module xlat_seq #(
  parameter int unsigned LO_W   = 4,
  parameter int unsigned HI_W   = 3,
  parameter int unsigned BYTE_W = LO_W + HI_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              uv_i,
  input  logic              smp_vld_i,
  input  logic [LO_W-1:0]   lo_code_i,
  input  logic [HI_W-1:0]   hi_code_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              ready_o
);
  import xlat_pkg::*;

  xlat_st_e          state_q;
  logic [BYTE_W-1:0] byte_q;
  logic              shut;
  logic              take;

  assign shut = !en_i || uv_i;
  assign take = (state_q == ST_WAIT) && smp_vld_i && !shut;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      byte_q  <= '0;
    end else if (shut) begin
      state_q <= ST_OFF;
      byte_q  <= '0;
    end else begin
      unique case (state_q)
        ST_OFF:  state_q <= ST_WAIT;
        ST_WAIT: if (take) begin
          byte_q  <= {hi_code_i, lo_code_i, 1'b0};  // rw bit kept clear
          state_q <= ST_LOAD;
        end
        ST_LOAD: state_q <= ST_RUN;
        ST_RUN:  state_q <= ST_RUN;
        default: state_q <= ST_OFF;
      endcase
    end
  end

  assign byte_o  = byte_q;
  assign ready_o = (state_q == ST_RUN);

  // R8
  shut_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shut |=> (byte_q == '0) && !ready_o);

  // R6
  wait_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_RUN && state_q != ST_LOAD && !take) |=> (byte_q == '0));

  // R7
  ready_late_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(state_q == ST_LOAD));

  // R9
  run_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && $past(ready_o)) |-> $stable(byte_q));
endmodule

// File: rtl/xlat_apply.sv
module xlat_apply #(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              act_i,
  input  logic [ADDR_W-1:0] xlat_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  always_comb begin
    addr_o = addr_i;
    if (act_i) addr_o = addr_i ^ xlat_i;
  end

  // R4
  always_comb rw_keep_chk: assert (addr_o[0] == addr_i[0]);
endmodule

// File: rtl/xlat_cfg_ctrl.sv
module xlat_cfg_ctrl #(
  parameter int unsigned RATIO_W = 8,
  parameter int unsigned LO_W    = 4,
  parameter int unsigned HI_W    = 3,
  localparam int unsigned ADDR_W = LO_W + HI_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               uv_i,
  input  logic               smp_vld_i,
  input  logic [RATIO_W-1:0] ratio_lo_i,
  input  logic [RATIO_W-1:0] ratio_hi_i,
  input  logic [ADDR_W-1:0]  addr_i,
  output logic [ADDR_W-1:0]  xlat_byte_o,
  output logic               ready_o,
  output logic               sw_en_o,
  output logic [ADDR_W-1:0]  addr_o
);
  logic [LO_W-1:0]   lo_code;
  logic [HI_W-1:0]   hi_code;
  logic [ADDR_W-1:0] xlat;
  logic              rdy;

  xlat_quant #(.RATIO_W(RATIO_W), .FIELD_W(LO_W)) quant_lo_i (
    .ratio_i (ratio_lo_i),
    .code_o  (lo_code)
  );

  xlat_quant #(.RATIO_W(RATIO_W), .FIELD_W(HI_W)) quant_hi_i (
    .ratio_i (ratio_hi_i),
    .code_o  (hi_code)
  );

  xlat_seq #(.LO_W(LO_W), .HI_W(HI_W), .BYTE_W(ADDR_W)) seq_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .uv_i      (uv_i),
    .smp_vld_i (smp_vld_i),
    .lo_code_i (lo_code),
    .hi_code_i (hi_code),
    .byte_o    (xlat),
    .ready_o   (rdy)
  );

  xlat_apply #(.ADDR_W(ADDR_W)) apply_i (
    .act_i  (rdy),
    .xlat_i (xlat),
    .addr_i (addr_i),
    .addr_o (addr_o)
  );

  assign xlat_byte_o = xlat;
  assign ready_o     = rdy;
  assign sw_en_o     = rdy;
endmodule

// File: tb/xlat_cfg_ctrl_tb_top.sv
`timescale 1ns/1ps
module xlat_cfg_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0, uv = 1'b0, smp = 1'b0;
  logic [7:0] r_lo = '0, r_hi = '0, a_in = '0;
  logic [7:0] xb, a_out;
  logic       rdy, sw;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  xlat_cfg_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .uv_i(uv), .smp_vld_i(smp),
    .ratio_lo_i(r_lo), .ratio_hi_i(r_hi), .addr_i(a_in),
    .xlat_byte_o(xb), .ready_o(rdy), .sw_en_o(sw), .addr_o(a_out)
  );

  function automatic logic [7:0] exp_byte(logic [7:0] lo, logic [7:0] hi);
    logic [2:0] h;
    h = hi[7] ? 3'd7 : hi[6:4];
    return {h, lo[7:4], 1'b0};
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic shut_down();
    en = 1'b0; tick(); tick();
  endtask

  // full bring-up; checks latch timing (R7) on the way
  task automatic bring_up(logic [7:0] lo, logic [7:0] hi, string tag);
    en = 1'b1; uv = 1'b0; smp = 1'b0; tick();
    r_lo = lo; r_hi = hi; smp = 1'b1; tick();
    smp = 1'b0;
    chk({tag, " R7 byte latched"}, xb, exp_byte(lo, hi));
    chk("R7 ready not yet", {6'd0, sw, rdy}, 8'd0);
    tick();
    chk("R7 ready and switch", {6'd0, sw, rdy}, 8'd3);
  endtask

  task automatic t_reset();
    chk("R5 byte", xb, 8'h00);
    chk("R5 ready/sw", {6'd0, sw, rdy}, 8'd0);
  endtask

  task automatic t_example();
    bring_up(8'd24, 8'd56, "R1");
    chk("R1 R3 example 0x62", xb, 8'h62);
    chk("R4 lsb", {7'd0, xb[0]}, 8'd0);
    shut_down();
  endtask

  task automatic t_bins();
    logic [7:0] vals[6] = '{8'd15, 8'd16, 8'd31, 8'd32, 8'd127, 8'd200};
    foreach (vals[i]) begin
      bring_up(vals[i], 8'd0, "R1");
      chk("R1 low bin", {4'd0, xb[4:1]}, {4'd0, vals[i][7:4]});
      shut_down();
    end
  endtask

  task automatic t_extremes();
    bring_up(8'd8, 8'd0, "R2");
    chk("R2 low floor", {4'd0, xb[4:1]}, 8'd0);
    shut_down();
    bring_up(8'd248, 8'd0, "R2");
    chk("R2 low ceiling", {4'd0, xb[4:1]}, 8'd15);
    shut_down();
  endtask

  task automatic t_hi_sat();
    logic [7:0] vals[5] = '{8'd112, 8'd127, 8'd128, 8'd200, 8'd255};
    foreach (vals[i]) begin
      bring_up(8'd0, vals[i], "R3");
      chk("R3 high field", {5'd0, xb[7:5]},
          {5'd0, (vals[i] >= 8'd128) ? 3'd7 : vals[i][6:4]});
      shut_down();
    end
  endtask

  task automatic t_shared();
    bring_up(8'h50, 8'h50, "R11");
    chk("R11 shared ratio", xb, 8'hAA);
    shut_down();
  endtask

  task automatic t_wait_strobe();
    en = 1'b1; r_lo = 8'hF0; r_hi = 8'h70;
    repeat (5) tick();
    chk("R6 no strobe byte", xb, 8'h00);
    chk("R6 no strobe ready", {7'd0, rdy}, 8'd0);
    smp = 1'b1; tick(); smp = 1'b0; tick();
    chk("R6 after strobe", xb, exp_byte(8'hF0, 8'h70));
    shut_down();
  endtask

  task automatic t_retoggle();
    bring_up(8'h30, 8'h20, "R9");
    r_lo = 8'hC0; r_hi = 8'h60; smp = 1'b1; tick(); tick(); smp = 1'b0;
    chk("R9 strobe ignored while ready", xb, exp_byte(8'h30, 8'h20));
    en = 1'b0; tick();
    chk("R8 enable low clears", xb, 8'h00);
    chk("R8 enable low ready", {6'd0, sw, rdy}, 8'd0);
    bring_up(8'hC0, 8'h60, "R9");
    chk("R9 reload", xb, exp_byte(8'hC0, 8'h60));
  endtask

  task automatic t_uv();
    uv = 1'b1; tick();
    chk("R8 uv clears", xb, 8'h00);
    chk("R8 uv ready", {6'd0, sw, rdy}, 8'd0);
    uv = 1'b0;
    shut_down();
  endtask

  task automatic t_addr();
    a_in = 8'hA5; tick();
    chk("R10 passthrough", a_out, 8'hA5);
    bring_up(8'd24, 8'd56, "R10");
    a_in = 8'hA5; #1;
    chk("R10 xor", a_out, 8'hA5 ^ 8'h62);
    a_in = 8'h51; #1;
    chk("R4 rw bit kept", {7'd0, a_out[0]}, 8'd1);
    shut_down();
    chk("R10 passthrough after shutdown", a_out, 8'h51);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    t_reset();
    rst_n = 1'b1; tick();
    t_reset();
    t_example();
    t_bins();
    t_extremes();
    t_hi_sat();
    t_shared();
    t_wait_strobe();
    t_retoggle();
    t_uv();
    t_addr();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule